// File: doc/BRIEF.md
# I2C Host Controller

This block is a register-mapped I2C master for a single-master bus. A processor configures it and moves data through a small register file: a command register, a mode register that holds the 7-bit target address and the transfer direction, a status register, a receive data register and a transmit data register. It drives SCL and SDA as open-drain output enables and samples SDA while SCL is high. A quarter-period tick generator sets the SCL timing. Each bit lasts four quarters.

Writes are started by the data itself. When the block is idle in write mode, storing a byte in the transmit register sends a START, the address with R/W = 0, and then that byte. Reads need an explicit START command. In both directions, a STOP command ends the transfer after the byte in flight. In a read, that byte is answered with NACK. The complete flag rises only once the STOP condition is on the bus.

Every register write except the one to the key register is dropped until the right key has been written there.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset the status register (offset 0x20) reads 0x5 and both line enables are low (lines released). Status bits: 0 = complete, 1 = receive data full, 2 = transmit data free, 8 = NACK seen.
- R2: Writes to any offset other than 0xE4 are ignored until 0xE4 is written with 0x545749 in bits 31:8. A write of any other value there locks the block again.
- R3: Command register (offset 0x00) bits are write-one actions: bit 0 START, bit 1 STOP, bit 2 enable, bit 7 soft reset. Soft reset returns the status to 0x5, releases the lines and clears enable. No transfer starts while the block is not enabled.
- R4: Mode register (offset 0x04) holds the target address in bits 22:16 and the direction in bit 12 (1 = read). It reads back at the same positions. The address byte on the bus is {address, direction}, MSB first.
- R5: In write mode, a write to offset 0x34 while idle starts START, address byte and that data byte. Transmit-free drops at the write and rises when the shifter takes the byte, so the next byte can be queued.
- R6: In write mode, a STOP command issues STOP after the current byte's acknowledge. Complete rises only after the STOP condition.
- R7: In read mode, the START command starts the transfer. Each received byte sets receive-full and is read at offset 0x30. Reading offset 0x30 clears receive-full. The master ACKs each byte that is not the last.
- R8: A STOP command written while a read byte is in progress makes that byte the last one: it gets a NACK, then STOP, then complete.
- R9: If the target does not acknowledge the address or a data byte, the NACK flag sets, the master issues STOP and complete rises. Reading the status register clears the NACK flag.
- R10: While SCL is high, SDA falls only as a START with the bus idle, and rises only as a STOP ending a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions check on every cycle that:
- the lines are released whenever complete is set;
- a locked mode write leaves the mode register unchanged;
- a transmit write marks the holding byte as full;
- reading receive data clears receive-full;
- the NACK flag only rises while a transfer is still ending;
- take, receive and done events never coincide.

Only the bench scenarios can show the byte sequences on the wire, ACK or NACK by the master on read bytes, when STOP lands relative to a late STOP command, and the ordering of complete after STOP. The bench shows these with a behavioural target device and a bus decoder that checks the START and STOP rules at every clock.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;
  localparam logic [7:0]  OFS_CMD  = 8'h00;
  localparam logic [7:0]  OFS_MODE = 8'h04;
  localparam logic [7:0]  OFS_STAT = 8'h20;
  localparam logic [7:0]  OFS_RXD  = 8'h30;
  localparam logic [7:0]  OFS_TXD  = 8'h34;
  localparam logic [7:0]  OFS_KEY  = 8'hE4;
  localparam logic [23:0] KEY_VAL  = 24'h545749;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT, ST_ACK, ST_HOLD, ST_STOP
  } eng_state_t;
endpackage

// File: rtl/i2c_host_tick.sv
module i2c_host_tick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CW'(QDIV - 1));
    cnt_d = cnt_q + 1'b1;
    if (!run || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_host_engine.sv
module i2c_host_engine
  import i2c_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       go,
  input  logic       rd_mode,
  input  logic [6:0] dev_addr,
  input  logic       tx_valid,
  input  logic [7:0] tx_byte,
  input  logic       stop_req,
  input  logic       sda_in,
  output logic       busy,
  output logic       tx_take,
  output logic       rx_push,
  output logic [7:0] rx_byte,
  output logic       nack_evt,
  output logic       done,
  output logic       scl_oe,
  output logic       sda_oe
);
  eng_state_t st_q, st_d;
  logic [1:0] ph_q, ph_d;
  logic [2:0] bcnt_q, bcnt_d;
  logic [7:0] sh_q, sh_d;
  logic       is_addr_q, is_addr_d, rd_q, rd_d;
  logic       nout_q, nout_d, abad_q, abad_d;
  logic       rd_data, last_q;

  assign rd_data = rd_q && !is_addr_q;
  assign last_q  = tick && (ph_q == 2'd3);
  assign busy    = (st_q != ST_IDLE);
  assign rx_byte = sh_q;

  always_comb begin
    st_d = st_q; ph_d = ph_q; bcnt_d = bcnt_q; sh_d = sh_q;
    is_addr_d = is_addr_q; rd_d = rd_q; nout_d = nout_q; abad_d = abad_q;
    tx_take = 1'b0; rx_push = 1'b0; nack_evt = 1'b0; done = 1'b0;
    if (busy && tick) ph_d = ph_q + 2'd1;
    case (st_q)
      ST_IDLE: if (go) begin
        st_d = ST_START; ph_d = '0; sh_d = {dev_addr, rd_mode};
        rd_d = rd_mode; is_addr_d = 1'b1;
      end
      ST_START: if (last_q) begin
        st_d = ST_BIT; bcnt_d = 3'd7;
      end
      ST_BIT: if (tick) begin
        if (ph_q == 2'd1 && rd_data) sh_d = {sh_q[6:0], sda_in};
        if (ph_q == 2'd3) begin
          if (!rd_data) sh_d = {sh_q[6:0], 1'b0};
          if (bcnt_q == 3'd0) begin
            st_d = ST_ACK; nout_d = stop_req; rx_push = rd_data;
          end else bcnt_d = bcnt_q - 3'd1;
        end
      end
      ST_ACK: if (tick) begin
        if (ph_q == 2'd1) abad_d = sda_in;
        if (ph_q == 2'd3) begin
          bcnt_d = 3'd7;
          if (rd_data) st_d = nout_q ? ST_STOP : ST_BIT;
          else if (abad_q) begin
            nack_evt = 1'b1; st_d = ST_STOP;
          end else if (is_addr_q && rd_q) begin
            st_d = ST_BIT; is_addr_d = 1'b0;
          end else if (stop_req) st_d = ST_STOP;
          else if (tx_valid) begin
            st_d = ST_BIT; sh_d = tx_byte; tx_take = 1'b1; is_addr_d = 1'b0;
          end else begin
            st_d = ST_HOLD; is_addr_d = 1'b0;
          end
        end
      end
      ST_HOLD: begin
        ph_d = '0;
        if (tick) begin
          if (stop_req) st_d = ST_STOP;
          else if (tx_valid) begin
            st_d = ST_BIT; sh_d = tx_byte; tx_take = 1'b1; bcnt_d = 3'd7;
          end
        end
      end
      ST_STOP: if (last_q) begin
        st_d = ST_IDLE; done = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (clr) begin
      st_d = ST_IDLE; ph_d = '0;
      tx_take = 1'b0; rx_push = 1'b0; nack_evt = 1'b0; done = 1'b0;
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st_q)
      ST_START: begin scl_oe = (ph_q == 2'd3); sda_oe = (ph_q != 2'd0); end
      ST_BIT: begin
        scl_oe = (ph_q == 2'd0) || (ph_q == 2'd3);
        sda_oe = rd_data ? 1'b0 : !sh_q[7];
      end
      ST_ACK: begin
        scl_oe = (ph_q == 2'd0) || (ph_q == 2'd3);
        sda_oe = rd_data ? !nout_q : 1'b0;
      end
      ST_HOLD: scl_oe = 1'b1;
      ST_STOP: begin scl_oe = (ph_q == 2'd0); sda_oe = (ph_q <= 2'd1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ph_q <= '0; bcnt_q <= '0; sh_q <= '0;
      is_addr_q <= 1'b0; rd_q <= 1'b0; nout_q <= 1'b0; abad_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bcnt_q <= bcnt_d; sh_q <= sh_d;
      is_addr_q <= is_addr_d; rd_q <= rd_d; nout_q <= nout_d; abad_q <= abad_d;
    end
  end
endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
  import i2c_host_pkg::*;
#(
  parameter int QDIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  logic       unlock_q, unlock_d, men_q, men_d, rdm_q, rdm_d;
  logic [6:0] dev_q, dev_d;
  logic [7:0] txh_q, txh_d, rxh_q, rxh_d;
  logic       txv_q, txv_d, rxv_q, rxv_d, nack_q, nack_d;
  logic       cmpl_q, cmpl_d, stopr_q, stopr_d;
  logic       wr_ok, wr_cmd, swrst, go, tick;
  logic       eng_busy, eng_tx_take, eng_rx_push, eng_nack, eng_done;
  logic [7:0] eng_rx_byte;

  assign wr_ok  = bus_wr && unlock_q;
  assign wr_cmd = wr_ok && (bus_addr == OFS_CMD);
  assign swrst  = wr_cmd && bus_wdata[7];
  assign go     = !eng_busy && men_q && !swrst &&
                  ((wr_cmd && bus_wdata[0] && rdm_q) ||
                   (wr_ok && (bus_addr == OFS_TXD) && !rdm_q));

  i2c_host_tick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .tick(tick)
  );

  i2c_host_engine u_eng (
    .clk(clk), .rst_n(rst_n), .clr(swrst), .tick(tick), .go(go),
    .rd_mode(rdm_q), .dev_addr(dev_q), .tx_valid(txv_q), .tx_byte(txh_q),
    .stop_req(stopr_q), .sda_in(sda_in), .busy(eng_busy),
    .tx_take(eng_tx_take), .rx_push(eng_rx_push), .rx_byte(eng_rx_byte),
    .nack_evt(eng_nack), .done(eng_done), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_comb begin
    unlock_d = unlock_q; men_d = men_q; rdm_d = rdm_q; dev_d = dev_q;
    txh_d = txh_q; txv_d = txv_q; rxh_d = rxh_q; rxv_d = rxv_q;
    nack_d = nack_q; cmpl_d = cmpl_q; stopr_d = stopr_q;
    if (bus_wr && (bus_addr == OFS_KEY)) unlock_d = (bus_wdata[31:8] == KEY_VAL);
    if (swrst) begin
      men_d = 1'b0; txv_d = 1'b0; rxv_d = 1'b0; nack_d = 1'b0;
      cmpl_d = 1'b1; stopr_d = 1'b0;
    end else begin
      if (wr_cmd && bus_wdata[2]) men_d = 1'b1;
      if (wr_cmd && bus_wdata[1] && eng_busy) stopr_d = 1'b1;
      if (wr_ok && (bus_addr == OFS_MODE)) begin
        dev_d = bus_wdata[22:16];
        rdm_d = bus_wdata[12];
      end
      if (eng_tx_take) txv_d = 1'b0;
      if (go) cmpl_d = 1'b0;
      if (eng_done) begin
        cmpl_d = 1'b1; stopr_d = 1'b0; txv_d = 1'b0;
      end
      if (wr_ok && (bus_addr == OFS_TXD)) begin
        txh_d = bus_wdata[7:0];
        txv_d = 1'b1;
      end
      if (bus_rd && (bus_addr == OFS_RXD)) rxv_d = 1'b0;
      if (eng_rx_push) begin
        rxv_d = 1'b1; rxh_d = eng_rx_byte;
      end
      if (bus_rd && (bus_addr == OFS_STAT)) nack_d = 1'b0;
      if (eng_nack) nack_d = 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_STAT: begin
        bus_rdata[8] = nack_q; bus_rdata[2] = !txv_q;
        bus_rdata[1] = rxv_q;  bus_rdata[0] = cmpl_q;
      end
      OFS_MODE: begin
        bus_rdata[22:16] = dev_q; bus_rdata[12] = rdm_q;
      end
      OFS_RXD: bus_rdata[7:0] = rxh_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0; men_q <= 1'b0; rdm_q <= 1'b0; dev_q <= '0;
      txh_q <= '0; txv_q <= 1'b0; rxh_q <= '0; rxv_q <= 1'b0;
      nack_q <= 1'b0; cmpl_q <= 1'b1; stopr_q <= 1'b0;
    end else begin
      unlock_q <= unlock_d; men_q <= men_d; rdm_q <= rdm_d; dev_q <= dev_d;
      txh_q <= txh_d; txv_q <= txv_d; rxh_q <= rxh_d; rxv_q <= rxv_d;
      nack_q <= nack_d; cmpl_q <= cmpl_d; stopr_q <= stopr_d;
    end
  end
endmodule

// File: rtl/i2c_host_ctrl_chk.sv
module i2c_host_ctrl_chk
  import i2c_host_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_addr,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       unlock_q,
  input logic [6:0] dev_q,
  input logic       rdm_q,
  input logic       txv_q,
  input logic       rxv_q,
  input logic       nack_q,
  input logic       cmpl_q,
  input logic       eng_tx_take,
  input logic       eng_rx_push,
  input logic       eng_done
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_q |-> (!scl_oe && !sda_oe));

  a_r2_locked_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlock_q && bus_addr == OFS_MODE) |=> ($stable(dev_q) && $stable(rdm_q)));

  a_r5_txd_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unlock_q && bus_addr == OFS_TXD) |=> txv_q);

  a_r7_rxd_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_RXD && !eng_rx_push) |=> !rxv_q);

  a_r9_nack_before_complete: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_q) |-> !cmpl_q);

  a_r6_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_tx_take, eng_rx_push, eng_done}));
endmodule

bind i2c_host_ctrl i2c_host_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .unlock_q(unlock_q), .dev_q(dev_q),
  .rdm_q(rdm_q), .txv_q(txv_q), .rxv_q(rxv_q), .nack_q(nack_q), .cmpl_q(cmpl_q),
  .eng_tx_take(eng_tx_take), .eng_rx_push(eng_rx_push), .eng_done(eng_done)
);

// File: tb/tb_i2c_host_ctrl.sv
module tb_i2c_host_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic scl_oe, sda_oe;
  logic slv_pull = 1'b0;
  wire  sda_l = !(sda_oe || slv_pull);
  wire  scl_l = !scl_oe;

  int nchk = 0, nfail = 0;
  int start_cnt = 0, stop_cnt = 0;
  logic [7:0] mon_q[$];
  logic [7:0] rd_src[$];
  bit   mack_q[$];
  localparam logic [6:0] SLV = 7'h50;

  always #5 clk = !clk;

  i2c_host_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sda_in(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic poll(input int pos, output logic [31:0] sr, output bit saw_nack);
    saw_nack = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h20, sr);
      if (sr[8]) saw_nack = 1;
      if (sr[pos]) break;
    end
  endtask

  // Behavioural target device and bus decoder, evaluated every clock.
  bit p_scl = 1, p_sda = 1, in_x = 0, addr_ph = 0, is_rd = 0, acked = 0;
  int bitn = 0;
  logic [7:0] sh = '0, cur = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_scl && scl_l && (p_sda != sda_l)) begin
        if (!sda_l) begin
          chk(!in_x, "R10 START only on idle bus", in_x, 0);
          in_x = 1; bitn = 0; addr_ph = 1; slv_pull = 0; start_cnt++;
        end else begin
          chk(in_x, "R10 STOP only ends a transfer", in_x, 1);
          in_x = 0; slv_pull = 0; stop_cnt++;
        end
      end else if (in_x && !p_scl && scl_l) begin
        if (bitn < 8) sh = {sh[6:0], sda_l};
        else if (is_rd && !addr_ph) mack_q.push_back(!sda_l);
        bitn++;
      end else if (in_x && p_scl && !scl_l) begin
        if (bitn == 8) begin
          if (addr_ph) begin
            mon_q.push_back(sh); is_rd = sh[0]; acked = (sh[7:1] == SLV); slv_pull = acked;
          end else if (!is_rd) begin
            mon_q.push_back(sh); slv_pull = 1;
          end else slv_pull = 0;
        end else if (bitn == 9) begin
          bitn = 0;
          if (addr_ph) begin
            addr_ph = 0;
            if (is_rd && acked) begin
              cur = (rd_src.size() > 0) ? rd_src.pop_front() : 8'h00;
              slv_pull = !cur[7];
            end else slv_pull = 0;
          end else if (is_rd && mack_q.size() > 0 && mack_q[$]) begin
            cur = (rd_src.size() > 0) ? rd_src.pop_front() : 8'h00;
            slv_pull = !cur[7];
          end else slv_pull = 0;
        end else if (is_rd && !addr_ph && acked) slv_pull = !cur[7 - bitn];
      end
      p_scl = scl_l; p_sda = sda_l;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1-watchdog: run hung actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit sn;
    int sc;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(8'h20, d);
    chk(d == 32'h5, "R1 status after reset", d, 5);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

    // R2 locked: writes dropped
    wr(8'h04, 32'h0050_0000);
    rd(8'h04, d);
    chk(d == 0, "R2 locked mode write ignored", d, 0);
    wr(8'h00, 32'h4);
    wr(8'h34, 32'h11);
    repeat (300) @(negedge clk);
    chk(start_cnt == 0, "R2 locked transmit write starts nothing", start_cnt, 0);
    rd(8'h20, d);
    chk(d == 32'h5, "R2 locked status unchanged", d, 5);

    // unlock, R4 mode readback
    wr(8'hE4, {24'h545749, 8'h00});
    wr(8'h04, 32'h0050_0000);
    rd(8'h04, d);
    chk(d == 32'h0050_0000, "R4 mode readback", d, 32'h500000);
    wr(8'h00, 32'h4);

    // R5/R6 write of two bytes
    wr(8'h34, 32'hA5);
    rd(8'h20, d);
    chk(d == 32'h0, "R5 busy and transmit not free after write", d, 0);
    poll(2, d, sn);
    wr(8'h34, 32'h3C);
    poll(2, d, sn);
    wr(8'h00, 32'h2);
    poll(0, d, sn);
    chk(stop_cnt == 1, "R6 complete only after STOP", stop_cnt, 1);
    chk(mon_q.size() == 3, "R5 byte count on bus", mon_q.size(), 3);
    if (mon_q.size() == 3) begin
      chk(mon_q[0] == 8'hA0, "R4 address byte write", mon_q[0], 8'hA0);
      chk(mon_q[1] == 8'hA5, "R5 first data byte", mon_q[1], 8'hA5);
      chk(mon_q[2] == 8'h3C, "R6 byte before STOP sent", mon_q[2], 8'h3C);
    end

    // R7/R8 read of three bytes
    mon_q.delete(); mack_q.delete();
    rd_src.push_back(8'h81); rd_src.push_back(8'h7E); rd_src.push_back(8'h15);
    wr(8'h04, 32'h0050_1000);
    wr(8'h00, 32'h1);
    poll(1, d, sn); rd(8'h30, d);
    chk(d == 32'h81, "R7 first read byte", d, 8'h81);
    rd(8'h20, d);
    chk(d[1] == 1'b0, "R7 receive-full cleared by read", d[1], 0);
    poll(1, d, sn); rd(8'h30, d);
    chk(d == 32'h7E, "R7 second read byte", d, 8'h7E);
    wr(8'h00, 32'h2);
    poll(1, d, sn); rd(8'h30, d);
    chk(d == 32'h15, "R8 last read byte", d, 8'h15);
    poll(0, d, sn);
    chk(stop_cnt == 2, "R8 STOP before complete", stop_cnt, 2);
    chk(mon_q.size() == 1 && mon_q[0] == 8'hA1, "R4 address byte read", mon_q[0], 8'hA1);
    chk(mack_q.size() == 3, "R8 three bytes read", mack_q.size(), 3);
    if (mack_q.size() == 3)
      chk(mack_q[0] && mack_q[1] && !mack_q[2], "R8 ACK,ACK,NACK by master",
          {mack_q[0], mack_q[1], mack_q[2]}, 3'b110);

    // R9 address not acknowledged
    mon_q.delete();
    wr(8'h04, 32'h0022_0000);
    wr(8'h34, 32'h11);
    poll(0, d, sn);
    chk(sn, "R9 NACK flag seen", sn, 1);
    chk(stop_cnt == 3, "R9 STOP after NACK", stop_cnt, 3);
    chk(mon_q.size() == 1, "R9 no data after NACK", mon_q.size(), 1);
    rd(8'h20, d);
    chk(d == 32'h5, "R9 NACK cleared by status read", d, 5);

    // R3 soft reset mid transfer, then enable cleared
    wr(8'h04, 32'h0050_0000);
    wr(8'h34, 32'h77);
    repeat (40) @(negedge clk);
    wr(8'h00, 32'h80);
    rd(8'h20, d);
    chk(d == 32'h5, "R3 soft reset status", d, 5);
    chk(!scl_oe && !sda_oe, "R3 soft reset releases lines", {scl_oe, sda_oe}, 0);
    sc = start_cnt;
    wr(8'h34, 32'h99);
    repeat (200) @(negedge clk);
    chk(start_cnt == sc, "R3 no transfer while disabled", start_cnt, sc);

    summary();
    $finish;
  end
endmodule